// File: doc/BRIEF.md
# Compressed-instruction fetch realignment buffer

This block sits between a fetch port that delivers naturally aligned 32-bit words and an instruction decoder. The instruction stream mixes 16-bit and 32-bit encodings, and a 32-bit encoding only has to be halfword aligned, so it can start in the upper half of one fetch word and finish in the lower half of the next. The block keeps unused halfwords in a small ring and offers the decoder one complete instruction per cycle. Each instruction comes with its length and its program counter.

The length rule is fixed. When the two lowest bits of a halfword are both 1, that halfword opens a 32-bit instruction. Any other pattern in those bits marks a complete 16-bit instruction. A halfword that opens a 32-bit instruction may sit alone in the ring while the next word arrives. The block therefore keeps accepting fetch words whenever the ring has room for a whole word after this cycle's issue. As a result, a straddling instruction issues in the cycle right after its second half is accepted, with no stall bubble.

A redirect moves the stream to any halfword-aligned target. It empties the ring and sets the word address that the block expects next. Fetch words that arrive with any other address are stale: the block takes them off the port and drops them. When the target is the upper half of a word, the lower half of that first word is dropped.

Top module: `insn_realign`

## Requirements
- R1: A head halfword whose bits [1:0] are not 2'b11 issues as a 16-bit instruction: `out_wide`=0 and `out_instr` = {16'h0000, halfword}.
- R2: A head halfword whose bits [1:0] are 2'b11 issues as a 32-bit instruction: `out_wide`=1 and `out_instr` = {following halfword, head halfword}. It issues only when both halfwords are held.
- R3: After each issue handshake, `out_pc` advances by 4 for a 32-bit instruction and by 2 for a 16-bit one.
- R4: A redirect empties the buffer. The next instruction issued has `out_pc` equal to the target with bit 0 cleared, and its bits are read from that address. If target bit 1 is set, the lower halfword of the word at target & ~3 is dropped.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_instr`, `out_wide` and `out_pc` hold their values into the next cycle, unless a redirect occurs.
- R6: A fetch word at the expected address is accepted only if at least two halfword slots are free after this cycle's issue. The ring never holds more than DEPTH halfwords, and a stalled decoder eventually drops `in_ready`.
- R7: With fetch words always offered and the decoder always ready, a run of 32-bit instructions that each straddle a word boundary issues one per cycle.
- R8: A fetch word whose address differs from the expected word address is accepted (`in_ready`=1) and discarded. It does not affect the issued stream.
- R9: In a cycle with `redirect_valid` high, `out_valid` and `in_ready` are both low.
- R10: After reset the buffer is empty: `out_valid`=0 and `out_pc`=RESET_PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| redirect_valid | input | 1 | Flush and restart at `redirect_pc` |
| redirect_pc | input | XLEN | Halfword-aligned restart address |
| in_valid | input | 1 | Fetch word offered |
| in_addr | input | XLEN | Word-aligned address of the fetch word |
| in_data | input | 32 | Fetch word; lower address in bits [15:0] |
| in_ready | output | 1 | Fetch word taken this cycle |
| out_valid | output | 1 | Complete instruction offered |
| out_ready | input | 1 | Decoder takes the instruction |
| out_instr | output | 32 | Instruction bits, upper half zero for 16-bit |
| out_wide | output | 1 | 1 for a 32-bit instruction |
| out_pc | output | XLEN | Address of the offered instruction |

## Verification
The ring head drives the output combinationally. An instruction whose last halfword arrives in a word accepted at a clock edge is therefore offered in the cycle that starts at that edge. The cycle after a redirect shows `out_pc` at the target, and the first instruction can be offered at the earliest one cycle after the first matching word is accepted. Inputs change one time unit after the rising edge and every observation is made on the falling edge, so each result is judged in the cycle its handshake completes. A scoreboard queue holds the instructions expected from the target, and the monitor compares one entry per issue handshake. It also checks the output is held in the cycle after a stall, and counts consecutive issues to confirm that straddling instructions issue without a bubble.

// File: rtl/insn_realign_pkg.sv
// Package: shared halfword/word types and the length rule for the
// realignment buffer. Assumes little-endian halfword order in a word.
package insn_realign_pkg;
    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;

    typedef logic [HALF_W-1:0] half_t;
    typedef logic [WORD_W-1:0] word_t;

    // True when the halfword opens a 32-bit encoding.
    function automatic logic half_is_wide(input half_t h);
        return (h[1:0] == 2'b11);
    endfunction
endpackage

// File: rtl/insn_hw_ring.sv
// Halfword ring: up to two pushes and two pops per cycle, with a head
// view of the two oldest entries. Assumes callers never push past DEPTH
// nor pop more than cnt; flush empties it in one cycle.
module insn_hw_ring
    import insn_realign_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic [1:0]                   push_n,
    input  half_t                        push_h0,
    input  half_t                        push_h1,
    input  logic [1:0]                   pop_n,
    output logic [$clog2(DEPTH+1)-1:0]   cnt,
    output half_t                        head0,
    output half_t                        head1
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [PW-1:0] rd_nx1, rd_nx2, wr_nx1, wr_nx2;
    half_t         slot_q [DEPTH];
    half_t         slot_d [DEPTH];

    // Modular pointer step for any DEPTH.
    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign rd_nx1 = step(rd_ptr);
    assign rd_nx2 = step(rd_nx1);
    assign wr_nx1 = step(wr_ptr);
    assign wr_nx2 = step(wr_nx1);

    // Per-slot next value: first push lands at wr_ptr, second after it.
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        assign slot_d[s] = (push_n != 2'd0 && wr_ptr == PW'(s)) ? push_h0 :
                           (push_n == 2'd2 && wr_nx1 == PW'(s)) ? push_h1 :
                           slot_q[s];
    end

    // Slot storage register.
    always_ff @(posedge clk) begin
        for (int s = 0; s < DEPTH; s++) begin
            if (!rst_n) slot_q[s] <= '0;
            else        slot_q[s] <= slot_d[s];
        end
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            rd_ptr <= (pop_n == 2'd2) ? rd_nx2 : (pop_n == 2'd1) ? rd_nx1 : rd_ptr;
            wr_ptr <= (push_n == 2'd2) ? wr_nx2 : (push_n == 2'd1) ? wr_nx1 : wr_ptr;
            cnt    <= cnt + CW'(push_n) - CW'(pop_n);
        end
    end

    assign head0 = slot_q[rd_ptr];
    assign head1 = slot_q[rd_nx1];
endmodule

// File: rtl/insn_word_gate.sv
// Fetch-side gate: tracks the next expected word address, drops stale
// words, discards the lower half of the first word after a redirect to
// an odd halfword, and turns accepted words into ring pushes.
// Assumes in_addr is word aligned.
module insn_word_gate
    import insn_realign_pkg::*;
#(
    parameter int               XLEN     = 32,
    parameter logic [XLEN-1:0]  RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            redirect_valid,
    input  logic [XLEN-1:0] redirect_pc,
    input  logic            in_valid,
    input  logic [XLEN-1:0] in_addr,
    input  word_t           in_data,
    input  logic            space_ok,
    output logic            in_ready,
    output logic [1:0]      push_n,
    output half_t           push_h0,
    output half_t           push_h1
);
    localparam logic [XLEN-1:0] WORD_MASK = ~XLEN'(3);
    localparam logic [XLEN-1:0] WORD_STEP = XLEN'(4);

    logic [XLEN-1:0] exp_addr;
    logic            skip_low;
    logic            addr_hit;
    logic            take;

    assign addr_hit = (in_addr == exp_addr);
    assign in_ready = !redirect_valid && (!addr_hit || space_ok);
    assign take     = in_valid && in_ready && addr_hit;

    // Push selection: one halfword when the lower half is skipped.
    always_comb begin
        push_n  = 2'd0;
        push_h0 = in_data[HALF_W-1:0];
        push_h1 = in_data[WORD_W-1:HALF_W];
        if (take) begin
            if (skip_low) begin
                push_n  = 2'd1;
                push_h0 = in_data[WORD_W-1:HALF_W];
            end else begin
                push_n  = 2'd2;
            end
        end
    end

    // Expected word address and skip flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_addr <= RESET_PC & WORD_MASK;
            skip_low <= RESET_PC[1];
        end else if (redirect_valid) begin
            exp_addr <= redirect_pc & WORD_MASK;
            skip_low <= redirect_pc[1];
        end else if (take) begin
            exp_addr <= exp_addr + WORD_STEP;
            skip_low <= 1'b0;
        end
    end
endmodule

// File: rtl/insn_issue_ctl.sv
// Issue control: decides whether the ring head holds a whole instruction,
// forms the output bundle, tracks the program counter and computes the
// credit that lets the gate accept a full word. Assumes head0/head1 are
// the two oldest ring entries and cnt their occupancy.
module insn_issue_ctl
    import insn_realign_pkg::*;
#(
    parameter int               XLEN     = 32,
    parameter int               DEPTH    = 4,
    parameter logic [XLEN-1:0]  RESET_PC = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(DEPTH+1)-1:0]  cnt,
    input  half_t                       head0,
    input  half_t                       head1,
    input  logic                        redirect_valid,
    input  logic [XLEN-1:0]             redirect_pc,
    input  logic                        out_ready,
    output logic                        out_valid,
    output word_t                       out_instr,
    output logic                        out_wide,
    output logic [XLEN-1:0]             out_pc,
    output logic [1:0]                  pop_n,
    output logic                        space_ok
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int SW = CW + 1;
    localparam logic [XLEN-1:0] HALF_MASK = ~XLEN'(1);

    logic            whole;
    logic            fire;
    logic [SW-1:0]   fill_after;

    assign out_wide  = half_is_wide(head0);
    assign whole     = out_wide ? (cnt >= CW'(2)) : (cnt >= CW'(1));
    assign out_valid = whole && !redirect_valid;
    assign out_instr = out_wide ? {head1, head0} : {{HALF_W{1'b0}}, head0};
    assign fire      = out_valid && out_ready;
    assign pop_n     = fire ? (out_wide ? 2'd2 : 2'd1) : 2'd0;

    // Credit: a full word fits once this cycle's issue has left.
    assign fill_after = SW'(cnt) - SW'(pop_n) + SW'(2);
    assign space_ok   = (fill_after <= SW'(DEPTH));

    // Program counter of the head instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)              out_pc <= RESET_PC & HALF_MASK;
        else if (redirect_valid) out_pc <= redirect_pc & HALF_MASK;
        else if (fire)           out_pc <= out_pc + (out_wide ? XLEN'(4) : XLEN'(2));
    end
endmodule

// File: rtl/insn_realign.sv
// Top: realignment buffer between an aligned 32-bit fetch port and a
// decoder. Mixed 16/32-bit stream, 32-bit encodings halfword aligned.
// Assumes DEPTH >= 4 halfwords and halfword-aligned redirect targets.
module insn_realign
    import insn_realign_pkg::*;
#(
    parameter int               XLEN     = 32,
    parameter int               DEPTH    = 4,
    parameter logic [XLEN-1:0]  RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            redirect_valid,
    input  logic [XLEN-1:0] redirect_pc,
    input  logic            in_valid,
    input  logic [XLEN-1:0] in_addr,
    input  logic [31:0]     in_data,
    output logic            in_ready,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [31:0]     out_instr,
    output logic            out_wide,
    output logic [XLEN-1:0] out_pc
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] hw_cnt;
    half_t         head0, head1, push_h0, push_h1;
    logic [1:0]    push_n, pop_n;
    logic          space_ok;

    insn_word_gate #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_gate (
        .clk(clk), .rst_n(rst_n),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data),
        .space_ok(space_ok), .in_ready(in_ready),
        .push_n(push_n), .push_h0(push_h0), .push_h1(push_h1)
    );

    insn_hw_ring #(.DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst_n(rst_n), .flush(redirect_valid),
        .push_n(push_n), .push_h0(push_h0), .push_h1(push_h1),
        .pop_n(pop_n), .cnt(hw_cnt), .head0(head0), .head1(head1)
    );

    insn_issue_ctl #(.XLEN(XLEN), .DEPTH(DEPTH), .RESET_PC(RESET_PC)) u_issue (
        .clk(clk), .rst_n(rst_n), .cnt(hw_cnt),
        .head0(head0), .head1(head1),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .out_ready(out_ready), .out_valid(out_valid), .out_instr(out_instr),
        .out_wide(out_wide), .out_pc(out_pc), .pop_n(pop_n), .space_ok(space_ok)
    );
endmodule

// File: rtl/insn_realign_chk.sv
// Checker: temporal properties of the realignment buffer, bound to the
// top. Sees the ring occupancy in addition to the ports.
module insn_realign_chk #(
    parameter int XLEN  = 32,
    parameter int DEPTH = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        redirect_valid,
    input logic [XLEN-1:0]             redirect_pc,
    input logic                        in_ready,
    input logic                        out_valid,
    input logic                        out_ready,
    input logic [31:0]                 out_instr,
    input logic                        out_wide,
    input logic [XLEN-1:0]             out_pc,
    input logic [$clog2(DEPTH+1)-1:0]  hw_cnt
);
    localparam int CW = $clog2(DEPTH + 1);

    // R1: a 16-bit issue carries a zero upper half.
    p_narrow_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_wide) |-> (out_instr[31:16] == 16'h0000));

    // R2: a wide issue needs both halfwords in the ring.
    p_wide_complete_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_wide) |-> (hw_cnt >= CW'(2)));

    // R3: pc step after a handshake.
    p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=>
        (out_pc == $past(out_pc) + ($past(out_wide) ? XLEN'(4) : XLEN'(2))));

    // R4: pc restarts at the redirect target.
    p_redirect_pc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> (out_pc == ($past(redirect_pc) & ~XLEN'(1))));

    // R5: stalled output holds.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !redirect_valid) |=>
        (redirect_valid || (out_valid && $stable(out_instr) &&
                            $stable(out_wide) && $stable(out_pc))));

    // R6: occupancy never exceeds the ring.
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hw_cnt <= CW'(DEPTH));

    // R9: redirect cycle is quiet on both sides.
    p_redirect_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (!out_valid && !in_ready));
endmodule

bind insn_realign insn_realign_chk #(.XLEN(XLEN), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_instr(out_instr), .out_wide(out_wide), .out_pc(out_pc),
    .hw_cnt(hw_cnt)
);

// File: tb/insn_realign_bench.sv
// Scoreboard bench: a fetch model serves words from a computed program,
// redirect tasks push the expected instruction stream into a queue, and a
// falling-edge monitor pops and compares on every issue handshake.
module insn_realign_bench;
    localparam int XLEN  = 32;
    localparam int DEPTH = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            redirect_valid = 1'b0;
    logic [XLEN-1:0] redirect_pc = '0;
    logic            in_valid = 1'b0;
    logic [XLEN-1:0] in_addr = '0;
    logic [31:0]     in_data = '0;
    logic            in_ready;
    logic            out_valid;
    logic            out_ready = 1'b0;
    logic [31:0]     out_instr;
    logic            out_wide;
    logic [XLEN-1:0] out_pc;

    always #4 clk = ~clk;   // 125 MHz

    insn_realign #(.XLEN(XLEN), .DEPTH(DEPTH), .RESET_PC('0)) u_insn_realign (
        .clk(clk), .rst_n(rst_n),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_instr(out_instr), .out_wide(out_wide), .out_pc(out_pc)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct { logic [31:0] pc; logic [31:0] instr; logic wide; } exp_t;
    exp_t sb[$];
    bit   first_item = 0;

    // Program: halfwords 0..63 all open 32-bit encodings; the rest mixed.
    function automatic logic [15:0] prog_hw(input int idx);
        int i, h;
        logic [1:0] lo;
        i = idx % 256;
        if (i < 64) return {8'(i), 6'(i * 3), 2'b11};
        h = i * 37 + 11;
        case (h % 5)
            0, 1:    lo = 2'b11;
            2:       lo = 2'b00;
            3:       lo = 2'b01;
            default: lo = 2'b10;
        endcase
        return {8'(i), 6'(h), lo};
    endfunction

    function automatic logic [31:0] word_at(input int a);
        return {prog_hw(a / 2 + 1), prog_hw(a / 2)};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver side of the scoreboard: expected stream from a start address.
    task automatic push_expect(input int start, input int n);
        int p;
        logic [15:0] h0;
        exp_t e;
        sb.delete();
        p = start;
        for (int k = 0; k < n; k++) begin
            h0 = prog_hw(p / 2);
            e.pc = 32'(p);
            if (h0[1:0] == 2'b11) begin
                e.instr = {prog_hw(p / 2 + 1), h0};
                e.wide  = 1'b1;
                p += 4;
            end else begin
                e.instr = {16'h0000, h0};
                e.wide  = 1'b0;
                p += 2;
            end
            sb.push_back(e);
        end
        first_item = 1;
    endtask

    // Fetch model and decoder-ready pattern.
    int   fptr = 0;
    bit   stale_pending = 0;
    bit   fetch_en = 0, gaps_en = 0, rdy_random = 0, rdy_level = 0;
    bit   in_fire_q = 0, redir_q = 0;
    int   redir_target = 0;
    logic [15:0] lfsr = 16'hACE1;

    initial begin
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (redir_q) begin
                fptr = redir_target & ~3;
                stale_pending = 1;
            end else if (in_fire_q) begin
                if (stale_pending) stale_pending = 0;
                else               fptr += 4;
            end
            in_valid  = fetch_en && (!gaps_en || lfsr[0] || lfsr[3]);
            in_addr   = 32'(stale_pending ? fptr + 64 : fptr);
            in_data   = stale_pending ? 32'hDEAD_BEEF : word_at(fptr);
            out_ready = rdy_random ? (lfsr[5] || lfsr[9]) : rdy_level;
        end
    end

    // Monitor: compare issues, hold behaviour and redirect quietness.
    bit          hold_q = 0;
    logic [31:0] hold_instr, hold_pc;
    logic        hold_wide;
    int          consec = 0, max_consec = 0;

    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (redirect_valid) begin
                    check(!out_valid && !in_ready, "R9", "quiet during redirect",
                          {30'd0, out_valid, in_ready}, 32'd0);
                end
                if (hold_q && !redirect_valid) begin
                    check(out_valid && out_instr == hold_instr && out_pc == hold_pc &&
                          out_wide == hold_wide, "R5", "stalled output held",
                          out_pc, hold_pc);
                end
                if (in_valid && stale_pending && !redirect_valid) begin
                    check(in_ready, "R8", "stale word taken", {31'd0, in_ready}, 32'd1);
                end
                if (out_valid && out_ready) begin
                    consec++;
                    if (consec > max_consec) max_consec = consec;
                    if (sb.size() == 0) begin
                        check(0, "R3", "issue with empty scoreboard", out_pc, 32'hFFFF_FFFF);
                    end else begin
                        e = sb.pop_front();
                        check(out_pc == e.pc, first_item ? "R4" : "R3", "pc",
                              out_pc, e.pc);
                        check(out_wide == e.wide, e.wide ? "R2" : "R1", "length",
                              {31'd0, out_wide}, {31'd0, e.wide});
                        check(out_instr == e.instr, e.wide ? "R2" : "R1", "instr",
                              out_instr, e.instr);
                        first_item = 0;
                    end
                end else begin
                    consec = 0;
                end
                hold_q     = out_valid && !out_ready && !redirect_valid;
                hold_instr = out_instr;
                hold_pc    = out_pc;
                hold_wide  = out_wide;
            end
            in_fire_q = in_valid && in_ready;
            redir_q   = redirect_valid;
            if (redirect_valid) redir_target = int'(redirect_pc);
        end
    end

    task automatic redirect_to(input int t);
        @(posedge clk); #1;
        redirect_valid = 1'b1;
        redirect_pc    = 32'(t);
        push_expect(t, 300);
        consec = 0; max_consec = 0;
        @(posedge clk); #1;
        redirect_valid = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        run(5);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid, "R10", "out_valid after reset", {31'd0, out_valid}, 32'd0);
        check(out_pc == 32'd0, "R10", "out_pc after reset", out_pc, 32'd0);

        // Aligned all-wide stream from reset address, random decoder ready.
        push_expect(0, 300);
        @(posedge clk); #1;
        fetch_en = 1; rdy_random = 1;
        run(40);

        // R1/R2/R4: mixed region, misaligned target, gaps on both sides.
        gaps_en = 1;
        redirect_to(32'h86);
        run(150);

        // R3: aligned target, decoder always ready.
        rdy_random = 0; rdy_level = 1;
        redirect_to(32'h100);
        run(100);

        // R6/R5: decoder stalled, ring fills and fetch is refused.
        gaps_en = 0; rdy_level = 0;
        redirect_to(32'h140);
        run(12);
        @(negedge clk);
        check(in_valid && !stale_pending && !in_ready, "R6", "ready low when full",
              {31'd0, in_ready}, 32'd0);
        check(out_valid, "R6", "instruction waiting", {31'd0, out_valid}, 32'd1);
        @(posedge clk); #1;
        rdy_random = 1;
        run(60);

        // R7: straddling wide instructions, no bubble.
        rdy_random = 0; rdy_level = 1;
        redirect_to(32'h2);
        run(40);
        check(max_consec >= 16, "R7", "consecutive issues", 32'(max_consec), 32'd16);

        // R4: back-to-back redirects; the second wins.
        rdy_random = 1; gaps_en = 1;
        @(posedge clk); #1;
        redirect_valid = 1'b1; redirect_pc = 32'h90;  push_expect(32'h90, 300);
        @(posedge clk); #1;
        redirect_pc = 32'h1A2; push_expect(32'h1A2, 300);
        @(posedge clk); #1;
        redirect_valid = 1'b0;
        run(120);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            summary();
            $finish;
        end
    end
endmodule